// File: doc/BRIEF.md
# Effective Address and Next-PC Unit

This unit sits beside the decode stage of a 16-bit, word-addressed processor. It takes the instruction register, the already incremented program counter, the value of the base register that the rest of the pipeline selected from IR[8:6], and the three condition flags (negative, zero, positive). From these it works out the memory address the instruction will use and the program counter the machine should fetch from next.

Four ways of forming an address are supported. PC-relative adds a sign-extended 9-bit offset to the incremented PC. Base-relative adds a sign-extended 6-bit offset to the base register. Address-only (load effective address) uses the PC-relative sum. Indirect access uses the PC-relative sum as the pointer address for its first stage. No address is ever taken directly from the instruction word. Conditional branches are resolved against a 3-bit flag mask, and register jumps are always taken.

All three results are captured in registers on a load strobe. They therefore stay fixed while a slow memory access that may take several cycles is in progress.

Top module: `eanpc_unit`

## Requirements
- R1: A low `rst_n` at a rising clock edge clears `ea_out`, `next_pc` and `taken` to zero. Reset takes priority over `load` when both are active at the same edge.
- R2: While `load` is low, `ea_out`, `next_pc` and `taken` keep their values, whatever the other inputs do.
- R3: For opcodes IR[15:12] = 0010, 0011, 1010, 1011 and 1110, `ea_out` becomes `pc_inc` plus the sign-extended IR[8:0]. For 1010 and 1011 this value is the pointer address of the indirect first stage. `next_pc` becomes `pc_inc` and `taken` becomes 0.
- R4: For opcodes 0110 and 0111, `ea_out` becomes `base_val` plus the sign-extended IR[5:0]. `next_pc` becomes `pc_inc` and `taken` becomes 0.
- R5: For opcode 0000 (conditional branch), `ea_out` becomes the branch target, which is `pc_inc` plus the sign-extended IR[8:0]. The branch is taken when any of these holds: IR[11] and `flag_n` are both 1, IR[10] and `flag_z` are both 1, or IR[9] and `flag_p` are both 1. When taken, `next_pc` is the target. When not taken, `next_pc` is `pc_inc`. `taken` reports the decision.
- R6: A conditional branch with IR[11:9] = 000 is never taken. A branch with IR[11:9] = 111 is always taken when one flag is set.
- R7: For opcode 1100 (register jump), `taken` becomes 1, and both `next_pc` and `ea_out` become `base_val`.
- R8: All address sums wrap modulo 2^16. For example, xFFFF + 1 gives x0000.
- R9: Any other opcode gives `ea_out` = 0, `next_pc` = `pc_inc` and `taken` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load | input | 1 | Capture strobe for the outputs |
| ir | input | 16 | Instruction register |
| pc_inc | input | 16 | Program counter already incremented past this instruction |
| base_val | input | 16 | Contents of the base register named by IR[8:6] |
| flag_n | input | 1 | Negative condition flag |
| flag_z | input | 1 | Zero condition flag |
| flag_p | input | 1 | Positive condition flag |
| ea_out | output | 16 | Registered effective address |
| next_pc | output | 16 | Registered next program counter |
| taken | output | 1 | Registered control-transfer decision |

## Verification
Two events can fall on the same clock edge. First, a conditional branch resolves its target address and its taken decision in a single evaluation, so a not-taken branch must still report its target on `ea_out` while `next_pc` stays at `pc_inc`. The bench drives such branches with an empty mask and with a mask that does not match the flags, and checks both outputs. Second, reset and the load strobe can be asserted at the same edge. The bench raises both together after loading a non-zero result and expects all outputs to read zero.

// File: rtl/eanpc_pkg.sv
// Package: shared opcode constants and decode categories for the
// effective-address / next-PC unit. Assumes a 4-bit major opcode field.
package eanpc_pkg;
    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_BRC  = 4'b0000;
    localparam logic [OPC_W-1:0] OPC_LDP  = 4'b0010;
    localparam logic [OPC_W-1:0] OPC_STP  = 4'b0011;
    localparam logic [OPC_W-1:0] OPC_LDB  = 4'b0110;
    localparam logic [OPC_W-1:0] OPC_STB  = 4'b0111;
    localparam logic [OPC_W-1:0] OPC_LDIN = 4'b1010;
    localparam logic [OPC_W-1:0] OPC_STIN = 4'b1011;
    localparam logic [OPC_W-1:0] OPC_JREG = 4'b1100;
    localparam logic [OPC_W-1:0] OPC_ADDR = 4'b1110;

    // Which adder result feeds the effective address.
    typedef enum logic [1:0] {
        EA_NONE  = 2'd0,
        EA_PCREL = 2'd1,
        EA_BASE  = 2'd2,
        EA_REG   = 2'd3
    } ea_src_t;

    // How the next program counter is chosen.
    typedef enum logic [1:0] {
        FLOW_SEQ  = 2'd0,
        FLOW_COND = 2'd1,
        FLOW_JUMP = 2'd2
    } flow_t;
endpackage

// File: rtl/eanpc_decode.sv
// Module: eanpc_decode
// Maps the major opcode to an address source and a flow category.
// Purely combinational. Assumes the opcode constants from eanpc_pkg.
module eanpc_decode
    import eanpc_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output ea_src_t          ea_src,
    output flow_t            flow
);
    // Classify each opcode; unlisted opcodes fall to none/sequential.
    always_comb begin
        ea_src = EA_NONE;
        flow   = FLOW_SEQ;
        case (opcode)
            OPC_LDP, OPC_STP, OPC_LDIN, OPC_STIN, OPC_ADDR: ea_src = EA_PCREL;
            OPC_LDB, OPC_STB:                                ea_src = EA_BASE;
            OPC_BRC: begin
                ea_src = EA_PCREL;
                flow   = FLOW_COND;
            end
            OPC_JREG: begin
                ea_src = EA_REG;
                flow   = FLOW_JUMP;
            end
            default: begin
                ea_src = EA_NONE;
                flow   = FLOW_SEQ;
            end
        endcase
    end
endmodule

// File: rtl/eanpc_addr_gen.sv
// Module: eanpc_addr_gen
// Sign-extends the long and short offset fields, forms the PC-relative and
// base-relative sums, and selects the effective address. Sums wrap modulo
// 2**XLEN. Assumes SHORT_W < LONG_W < XLEN.
module eanpc_addr_gen
    import eanpc_pkg::*;
#(
    parameter int XLEN    = 16,
    parameter int LONG_W  = 9,
    parameter int SHORT_W = 6
) (
    input  logic [LONG_W-1:0] off_field,
    input  logic [XLEN-1:0]   pc_inc,
    input  logic [XLEN-1:0]   base_val,
    input  ea_src_t           ea_src,
    output logic [XLEN-1:0]   pcrel_sum,
    output logic [XLEN-1:0]   ea
);
    localparam int LONG_PAD  = XLEN - LONG_W;
    localparam int SHORT_PAD = XLEN - SHORT_W;

    logic [XLEN-1:0] long_ext;
    logic [XLEN-1:0] short_ext;
    logic [XLEN-1:0] base_sum;

    // Sign extension of both offset widths.
    assign long_ext  = {{LONG_PAD{off_field[LONG_W-1]}}, off_field};
    assign short_ext = {{SHORT_PAD{off_field[SHORT_W-1]}}, off_field[SHORT_W-1:0]};

    // Two independent adders; carry out of the top bit is dropped.
    assign pcrel_sum = pc_inc + long_ext;
    assign base_sum  = base_val + short_ext;

    // Effective address selection by decode category.
    always_comb begin
        case (ea_src)
            EA_PCREL: ea = pcrel_sum;
            EA_BASE:  ea = base_sum;
            EA_REG:   ea = base_val;
            default:  ea = '0;
        endcase
    end
endmodule

// File: rtl/eanpc_cond.sv
// Module: eanpc_cond
// Resolves a conditional branch: taken when any mask bit meets its set flag.
// Mask and flags share bit order {negative, zero, positive}.
module eanpc_cond #(
    parameter int NFLAG = 3
) (
    input  logic [NFLAG-1:0] mask,
    input  logic [NFLAG-1:0] flags,
    output logic             take
);
    logic [NFLAG-1:0] hit;

    // One match term per flag.
    for (genvar gi = 0; gi < NFLAG; gi++) begin : g_hit
        assign hit[gi] = mask[gi] & flags[gi];
    end

    // Any match takes the branch.
    assign take = |hit;
endmodule

// File: rtl/eanpc_unit.sv
// Module: eanpc_unit (top)
// Computes effective address, next PC and taken flag from the instruction,
// incremented PC, base register value and condition flags, and captures them
// on the load strobe. Assumes the caller has already selected base_val from
// IR[8:6]. Reset is synchronous, active low, and has priority over load.
module eanpc_unit
    import eanpc_pkg::*;
#(
    parameter int XLEN    = 16,
    parameter int LONG_W  = 9,
    parameter int SHORT_W = 6,
    parameter int NFLAG   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [XLEN-1:0] ir,
    input  logic [XLEN-1:0] pc_inc,
    input  logic [XLEN-1:0] base_val,
    input  logic            flag_n,
    input  logic            flag_z,
    input  logic            flag_p,
    output logic [XLEN-1:0] ea_out,
    output logic [XLEN-1:0] next_pc,
    output logic            taken
);
    localparam int OPC_LSB  = XLEN - OPC_W;
    localparam int MASK_LSB = OPC_LSB - NFLAG;

    logic [OPC_W-1:0] opcode;
    logic [NFLAG-1:0] mask;
    logic [NFLAG-1:0] flags;
    ea_src_t          ea_src;
    flow_t            flow;
    logic [XLEN-1:0]  pcrel_sum;
    logic [XLEN-1:0]  ea_calc;
    logic             cond_take;
    logic             take_d;
    logic [XLEN-1:0]  npc_d;

    assign opcode = ir[XLEN-1:OPC_LSB];
    assign mask   = ir[OPC_LSB-1:MASK_LSB];
    assign flags  = {flag_n, flag_z, flag_p};

    eanpc_decode u_decode (
        .opcode (opcode),
        .ea_src (ea_src),
        .flow   (flow)
    );

    eanpc_addr_gen #(
        .XLEN    (XLEN),
        .LONG_W  (LONG_W),
        .SHORT_W (SHORT_W)
    ) u_addr (
        .off_field (ir[LONG_W-1:0]),
        .pc_inc    (pc_inc),
        .base_val  (base_val),
        .ea_src    (ea_src),
        .pcrel_sum (pcrel_sum),
        .ea        (ea_calc)
    );

    eanpc_cond #(.NFLAG(NFLAG)) u_cond (
        .mask  (mask),
        .flags (flags),
        .take  (cond_take)
    );

    // Next-PC and taken selection by flow category.
    always_comb begin
        case (flow)
            FLOW_COND: begin
                take_d = cond_take;
                npc_d  = cond_take ? pcrel_sum : pc_inc;
            end
            FLOW_JUMP: begin
                take_d = 1'b1;
                npc_d  = base_val;
            end
            default: begin
                take_d = 1'b0;
                npc_d  = pc_inc;
            end
        endcase
    end

    // Output capture: reset first, then load, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_out  <= '0;
            next_pc <= '0;
            taken   <= 1'b0;
        end else if (load) begin
            ea_out  <= ea_calc;
            next_pc <= npc_d;
            taken   <= take_d;
        end
    end

    // R2: outputs hold while the strobe is low.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(ea_out) && $stable(next_pc) && $stable(taken)));

    // R7: a register jump is always taken, to the base value.
    a_r7_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (load && ir[XLEN-1:OPC_LSB] == OPC_JREG)
        |=> (taken && next_pc == $past(base_val)));

    // R6: an empty mask never takes and keeps the sequential PC.
    a_r6_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (load && ir[XLEN-1:OPC_LSB] == OPC_BRC && ir[OPC_LSB-1:MASK_LSB] == '0)
        |=> (!taken && next_pc == $past(pc_inc)));

    // R9: non-transfer opcodes never report taken.
    a_r9_no_take: assert property (@(posedge clk) disable iff (!rst_n)
        (load && ir[XLEN-1:OPC_LSB] != OPC_BRC && ir[XLEN-1:OPC_LSB] != OPC_JREG)
        |=> (!taken && next_pc == $past(pc_inc)));

    // R5: a not-taken branch leaves next_pc at the incremented PC.
    a_r5_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (load && ir[XLEN-1:OPC_LSB] == OPC_BRC
              && (ir[OPC_LSB-1:MASK_LSB] & {flag_n, flag_z, flag_p}) == '0)
        |=> (!taken && next_pc == $past(pc_inc)));
endmodule

// File: tb/eanpc_unit_bench.sv
module eanpc_unit_bench;
    typedef struct packed {
        logic [3:0]  req;
        logic [15:0] ir;
        logic [15:0] pc;
        logic [15:0] base;
        logic [2:0]  flg;
        logic [15:0] ea;
        logic [15:0] npc;
        logic        tk;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{4'd3, 16'h2005, 16'h3001, 16'h0000, 3'b000, 16'h3006, 16'h3001, 1'b0}, // R3 load +5
        '{4'd3, 16'h31FF, 16'h3000, 16'h0000, 3'b000, 16'h2FFF, 16'h3000, 1'b0}, // R3 store -1
        '{4'd3, 16'hA0FF, 16'h3001, 16'h1234, 3'b000, 16'h3100, 16'h3001, 1'b0}, // R3 indirect ptr
        '{4'd3, 16'hB100, 16'h3100, 16'h0000, 3'b010, 16'h3000, 16'h3100, 1'b0}, // R3 indirect -256
        '{4'd3, 16'hE2FF, 16'h3001, 16'hFFFF, 3'b000, 16'h3100, 16'h3001, 1'b0}, // R3 address-only
        '{4'd4, 16'h687F, 16'h3000, 16'h3100, 3'b000, 16'h30FF, 16'h3000, 1'b0}, // R4 base -1
        '{4'd4, 16'h709F, 16'h3000, 16'h4000, 3'b100, 16'h401F, 16'h3000, 1'b0}, // R4 base +31
        '{4'd5, 16'h0405, 16'h3005, 16'h0000, 3'b010, 16'h300A, 16'h300A, 1'b1}, // R5 z taken +5
        '{4'd6, 16'h0FFA, 16'h300A, 16'h0000, 3'b001, 16'h3004, 16'h3004, 1'b1}, // R6 mask 111
        '{4'd6, 16'h01FA, 16'h300A, 16'h0000, 3'b010, 16'h3004, 16'h300A, 1'b0}, // R6 mask 000
        '{4'd5, 16'h0803, 16'h3000, 16'h0000, 3'b001, 16'h3003, 16'h3000, 1'b0}, // R5 mismatch
        '{4'd7, 16'hC080, 16'h3000, 16'h5555, 3'b000, 16'h5555, 16'h5555, 1'b1}, // R7 jump
        '{4'd8, 16'hE001, 16'hFFFF, 16'h0000, 3'b000, 16'h0000, 16'hFFFF, 1'b0}, // R8 pc wrap
        '{4'd8, 16'h6020, 16'h3000, 16'h0000, 3'b000, 16'hFFE0, 16'h3000, 1'b0}, // R8 base wrap
        '{4'd9, 16'h1261, 16'h3003, 16'h7777, 3'b111, 16'h0000, 16'h3003, 1'b0}, // R9 operate
        '{4'd9, 16'hF025, 16'h3010, 16'h0000, 3'b010, 16'h0000, 16'h3010, 1'b0}  // R9 trap
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [15:0] ir = '0;
    logic [15:0] pc_inc = '0;
    logic [15:0] base_val = '0;
    logic        flag_n = 1'b0;
    logic        flag_z = 1'b0;
    logic        flag_p = 1'b0;
    logic [15:0] ea_out;
    logic [15:0] next_pc;
    logic        taken;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    eanpc_unit u_eanpc_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .ir       (ir),
        .pc_inc   (pc_inc),
        .base_val (base_val),
        .flag_n   (flag_n),
        .flag_z   (flag_z),
        .flag_p   (flag_p),
        .ea_out   (ea_out),
        .next_pc  (next_pc),
        .taken    (taken)
    );

    task automatic check(input int req, input logic [15:0] e_ea,
                         input logic [15:0] e_npc, input logic e_tk);
        checks++;
        if (ea_out !== e_ea || next_pc !== e_npc || taken !== e_tk) begin
            errors++;
            $display("FAIL R%0d: got ea=%h npc=%h tk=%b, expected ea=%h npc=%h tk=%b",
                     req, ea_out, next_pc, taken, e_ea, e_npc, e_tk);
        end
    endtask

    task automatic drive(input vec_t v);
        ir       = v.ir;
        pc_inc   = v.pc;
        base_val = v.base;
        {flag_n, flag_z, flag_p} = v.flg;
    endtask

    // One strobe: inputs and load set at a falling edge, captured at the
    // next rising edge, sampled at the falling edge after that.
    task automatic strobe(input vec_t v);
        @(negedge clk);
        drive(v);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        check(1, 16'h0000, 16'h0000, 1'b0);
        rst_n = 1'b1;

        // Table of vectors, covering R3 to R9.
        for (int i = 0; i < NV; i++) begin
            strobe(VEC[i]);
            check(int'(VEC[i].req), VEC[i].ea, VEC[i].npc, VEC[i].tk);
        end

        // R2: hold with load low while every input changes.
        strobe(VEC[11]);
        drive(VEC[0]);
        repeat (3) @(negedge clk);
        check(2, 16'h5555, 16'h5555, 1'b1);

        // R6: mask 111 with the negative flag alone set.
        strobe('{4'd6, 16'h0E02, 16'h2000, 16'h0000, 3'b100,
                 16'h2002, 16'h2002, 1'b1});
        check(6, 16'h2002, 16'h2002, 1'b1);

        // R5 (target still reported when not taken), all flags clear.
        strobe('{4'd5, 16'h0E02, 16'h2000, 16'h0000, 3'b000,
                 16'h2002, 16'h2000, 1'b0});
        check(5, 16'h2002, 16'h2000, 1'b0);

        // R1: reset and load at the same edge; reset wins.
        strobe(VEC[11]);
        @(negedge clk);
        drive(VEC[0]);
        load  = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        load  = 1'b0;
        rst_n = 1'b1;
        check(1, 16'h0000, 16'h0000, 1'b0);

        // R8: jump followed by a load after reset recovers normally.
        strobe(VEC[12]);
        check(8, 16'h0000, 16'hFFFF, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule